// File: doc/BRIEF.md
# Terminal Address Check and Status Register

This block sits beside the protocol core of a dual-redundant serial bus remote terminal. It checks the strapped terminal address, which is five address straps plus one parity strap. From that check and the broadcast enable it decides whether a received command word gets a response. It also keeps track of whether the command was a broadcast.

For every message the block assembles the 16-bit status word that the terminal sends back. The host's status requests are sampled at the moment the word is updated. Error events from the core go into the word. The block holds a status-enable strobe low while the word is on the parallel bus. It also keeps two host-visible latched flags: one for message errors and one for terminal failures. It gates the core's transmit data requests while the host reports busy.

Top module: `rt_addr_status`

## Requirements
- R1: `addr_err_n` is registered. One clock after the straps are sampled it is 0 if `addr_strap` together with `addr_par` has even parity, and 1 if the parity is odd. It resets to 1.
- R2: When `cmd_valid` is high, `respond` loads 1 in either of two cases. The first is that the straps have odd parity, `cmd_addr` equals `addr_strap` and `cmd_addr` is not 31. The second is that R3 flags a broadcast. `respond` holds its value between commands.
- R3: When `cmd_valid` is high, `bcast_hit` loads 1 if `cmd_addr` is 31 and `bcast_en` is 1, whatever the strap parity. With `bcast_en` at 0, address 31 gives `respond` = 0. Status bit 4 holds the `bcast_hit` value at the time of the update.
- R4: On `status_upd` the active-low inputs `srq_n`, `busy_n`, `ssflag_n` and `rtflag_n` are sampled into status bits 8, 3, 2 and 0. A low input sets its bit and a high input clears it. Between updates these bits hold.
- R5: On `status_upd`, status bit 1 is set only if all of these are true: `adbc_n` is 0, `respond` is 1, the illegal-command latch is clear, and the last command was a dynamic-bus-control mode command. Such a command has `cmd_subaddr` equal to 0 or 31, `cmd_wcnt` equal to 0, and `cmd_xmit` equal to 1.
- R6: `ill_cmd_n` is sampled in a cycle where `in_cmd` is 1 and was 0 in the cycle before. If it is 0 there, an illegal latch is set. Status bit 10 is the OR of the illegal latch and the format-error latch, taken at the update. Both latches clear on `new_grant`, and a set in the same cycle takes priority over the clear.
- R7: `data_req_out` equals `data_req_in`, except that it is forced to 0 when both of these hold: the last command had `cmd_xmit` = 1, and the current status busy bit (bit 3) is set.
- R8: `msg_err_n` goes to 0 one clock after `fmt_err`. It stays at 0 until a `new_grant`, and a new `fmt_err` in that same cycle keeps it at 0.
- R9: `rt_fail_n` latches to 0 one clock after `st_fail`. `status_upd` clears it, unless `st_fail` is also high in that cycle.
- R10: After `status_upd`, `status_word` carries `addr_strap` in bits 15..11, with bits 9, 7, 6 and 5 at 0. `status_en_n` is 0 for exactly STAT_EN_CYCLES (default 4) cycles, starting one clock after the update. A new update restarts that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_strap | input | 5 | Strapped terminal address |
| addr_par | input | 1 | Parity strap for the address |
| bcast_en | input | 1 | Allows address 31 to be treated as broadcast |
| cmd_valid | input | 1 | Pulse: a command word has been received |
| cmd_addr | input | 5 | Address field of the command |
| cmd_xmit | input | 1 | Transmit/receive bit of the command (1 = transmit) |
| cmd_subaddr | input | 5 | Subaddress field of the command |
| cmd_wcnt | input | 5 | Word count / mode code field of the command |
| in_cmd | input | 1 | High while the core services a command |
| ill_cmd_n | input | 1 | Host marks the command illegal (active low) |
| srq_n | input | 1 | Service request (active low) |
| busy_n | input | 1 | Subsystem busy (active low) |
| ssflag_n | input | 1 | Subsystem flag (active low) |
| rtflag_n | input | 1 | Terminal flag (active low) |
| adbc_n | input | 1 | Accept dynamic bus control (active low) |
| status_upd | input | 1 | Pulse: update the status word and put it on the bus |
| new_grant | input | 1 | Pulse: a new protocol sequence starts |
| fmt_err | input | 1 | Pulse: format or word error |
| st_fail | input | 1 | Pulse: self-test or watchdog failure |
| data_req_in | input | 1 | Core asks for a data transfer |
| addr_err_n | output | 1 | Address parity error (active low) |
| respond | output | 1 | The last command must be answered |
| bcast_hit | output | 1 | The last command was a broadcast |
| status_word | output | 16 | Assembled status word |
| status_en_n | output | 1 | Status word is on the parallel bus (active low) |
| msg_err_n | output | 1 | Latched message error (active low) |
| rt_fail_n | output | 1 | Latched terminal failure (active low) |
| data_req_out | output | 1 | Data request after the busy gating |

## Verification
Every registered result is due exactly one clock after the stimulus that causes it: the parity flag, the respond and broadcast decisions, the status word, the start of the enable window and both error flags. Only the busy gating of the data request acts in the same cycle, from the state already held.

The bench keeps its own behavioural model, which it advances on each rising edge from the same inputs. It compares every output a quarter period after that edge, so a result is checked in the first cycle it is due. Inputs change only on falling edges.

// File: rtl/rt_stat_pkg.sv
package rt_stat_pkg;
    localparam int ADDR_W   = 5;
    localparam int WORD_W   = 16;
    localparam int BIT_ME   = 10;
    localparam int BIT_SRQ  = 8;
    localparam int BIT_BCR  = 4;
    localparam int BIT_BUSY = 3;
    localparam int BIT_SSF  = 2;
    localparam int BIT_DBCA = 1;
    localparam int BIT_TF   = 0;

    typedef struct packed {
        logic srq;
        logic busy;
        logic ssf;
        logic tf;
    } host_bits_t;
endpackage

// File: rtl/rt_addr_check.sv
module rt_addr_check #(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_strap,
    input  logic          addr_par,
    input  logic          bcast_en,
    input  logic          cmd_valid,
    input  logic [AW-1:0] cmd_addr,
    output logic          addr_err_n,
    output logic          respond,
    output logic          bcast_hit
);
    localparam logic [AW-1:0] BC_ADDR = '1;

    typedef struct packed {
        logic aerr_n;
        logic resp;
        logic bc;
    } ac_state_t;

    ac_state_t st_d, st_q;
    logic par_ok;
    logic own_hit;
    logic bc_now;

    always_comb begin
        par_ok  = ^{addr_strap, addr_par};
        own_hit = par_ok && (cmd_addr == addr_strap) && (cmd_addr != BC_ADDR);
        bc_now  = bcast_en && (cmd_addr == BC_ADDR);
        st_d        = st_q;
        st_d.aerr_n = par_ok;
        if (cmd_valid) begin
            st_d.resp = own_hit || bc_now;
            st_d.bc   = bc_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{aerr_n: 1'b1, resp: 1'b0, bc: 1'b0};
        else        st_q <= st_d;
    end

    assign addr_err_n = st_q.aerr_n;
    assign respond    = st_q.resp;
    assign bcast_hit  = st_q.bc;

    assert_no_resp_bad_par_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !(^{addr_strap, addr_par}) && cmd_addr != BC_ADDR) |=> !respond);
    assert_bc_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !bcast_en) |=> !bcast_hit);
endmodule

// File: rtl/rt_flag_latch.sv
module rt_flag_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    typedef struct packed {
        logic f;
    } fl_state_t;

    fl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) st_d.f = 1'b0;
        if (set) st_d.f = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{f: 1'b0};
        else        st_q <= st_d;
    end

    assign flag = st_q.f;

    assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
    assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag);
endmodule

// File: rtl/rt_status_reg.sv
module rt_status_reg
    import rt_stat_pkg::*;
#(
    parameter int AW         = 5,
    parameter int WW         = 16,
    parameter int EN_CYCLES  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_strap,
    input  logic          status_upd,
    input  host_bits_t    host_n,
    input  logic          adbc_n,
    input  logic          cmd_valid,
    input  logic          cmd_xmit,
    input  logic [AW-1:0] cmd_subaddr,
    input  logic [AW-1:0] cmd_wcnt,
    input  logic          respond,
    input  logic          bcast_hit,
    input  logic          in_cmd,
    input  logic          ill_cmd_n,
    input  logic          new_grant,
    input  logic          fmt_flag,
    input  logic          data_req_in,
    output logic [WW-1:0] status_word,
    output logic          status_en_n,
    output logic          data_req_out
);
    localparam int CW = $clog2(EN_CYCLES + 1);

    typedef struct packed {
        logic [WW-1:0] word;
        logic [CW-1:0] cnt;
        logic          xmit;
        logic          dbc_cmd;
        logic          inc_prev;
        logic          ill;
    } sr_state_t;

    sr_state_t st_d, st_q;
    logic is_mode;
    logic ill_strobe;

    always_comb begin
        is_mode    = (cmd_subaddr == '0) || (cmd_subaddr == '1);
        ill_strobe = in_cmd && !st_q.inc_prev && !ill_cmd_n;
        st_d          = st_q;
        st_d.inc_prev = in_cmd;
        if (new_grant)  st_d.ill = 1'b0;
        if (ill_strobe) st_d.ill = 1'b1;
        if (cmd_valid) begin
            st_d.xmit    = cmd_xmit;
            st_d.dbc_cmd = is_mode && (cmd_wcnt == '0) && cmd_xmit;
        end
        if (st_q.cnt != '0) st_d.cnt = st_q.cnt - 1'b1;
        if (status_upd) begin
            st_d.word                = '0;
            st_d.word[WW-1 -: AW]    = addr_strap;
            st_d.word[BIT_ME]        = st_q.ill || fmt_flag;
            st_d.word[BIT_SRQ]       = !host_n.srq;
            st_d.word[BIT_BCR]       = bcast_hit;
            st_d.word[BIT_BUSY]      = !host_n.busy;
            st_d.word[BIT_SSF]       = !host_n.ssf;
            st_d.word[BIT_DBCA]      = !adbc_n && st_q.dbc_cmd && respond && !st_q.ill;
            st_d.word[BIT_TF]        = !host_n.tf;
            st_d.cnt                 = CW'(EN_CYCLES);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_word  = st_q.word;
    assign status_en_n  = (st_q.cnt == '0);
    assign data_req_out = data_req_in && !(st_q.xmit && st_q.word[BIT_BUSY]);

    assert_en_after_upd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        status_upd |=> !status_en_n);
    assert_en_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_en_n) |-> $past(status_upd));
    assert_busy_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.xmit && status_word[BIT_BUSY]) |-> !data_req_out);
    assert_word_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !status_upd |=> $stable(status_word));
endmodule

// File: rtl/rt_addr_status.sv
module rt_addr_status
    import rt_stat_pkg::*;
#(
    parameter int STAT_EN_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_strap,
    input  logic              addr_par,
    input  logic              bcast_en,
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              cmd_xmit,
    input  logic [ADDR_W-1:0] cmd_subaddr,
    input  logic [ADDR_W-1:0] cmd_wcnt,
    input  logic              in_cmd,
    input  logic              ill_cmd_n,
    input  logic              srq_n,
    input  logic              busy_n,
    input  logic              ssflag_n,
    input  logic              rtflag_n,
    input  logic              adbc_n,
    input  logic              status_upd,
    input  logic              new_grant,
    input  logic              fmt_err,
    input  logic              st_fail,
    input  logic              data_req_in,
    output logic              addr_err_n,
    output logic              respond,
    output logic              bcast_hit,
    output logic [WORD_W-1:0] status_word,
    output logic              status_en_n,
    output logic              msg_err_n,
    output logic              rt_fail_n,
    output logic              data_req_out
);
    host_bits_t host_n;
    logic fmt_flag;
    logic fail_flag;

    assign host_n = '{srq: srq_n, busy: busy_n, ssf: ssflag_n, tf: rtflag_n};

    rt_addr_check #(.AW(ADDR_W)) i_addr (
        .clk(clk), .rst_n(rst_n), .addr_strap(addr_strap), .addr_par(addr_par),
        .bcast_en(bcast_en), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
        .addr_err_n(addr_err_n), .respond(respond), .bcast_hit(bcast_hit)
    );

    rt_flag_latch i_fmt (
        .clk(clk), .rst_n(rst_n), .set(fmt_err), .clr(new_grant), .flag(fmt_flag)
    );

    rt_flag_latch i_fail (
        .clk(clk), .rst_n(rst_n), .set(st_fail), .clr(status_upd), .flag(fail_flag)
    );

    rt_status_reg #(.AW(ADDR_W), .WW(WORD_W), .EN_CYCLES(STAT_EN_CYCLES)) i_stat (
        .clk(clk), .rst_n(rst_n), .addr_strap(addr_strap), .status_upd(status_upd),
        .host_n(host_n), .adbc_n(adbc_n), .cmd_valid(cmd_valid), .cmd_xmit(cmd_xmit),
        .cmd_subaddr(cmd_subaddr), .cmd_wcnt(cmd_wcnt), .respond(respond),
        .bcast_hit(bcast_hit), .in_cmd(in_cmd), .ill_cmd_n(ill_cmd_n),
        .new_grant(new_grant), .fmt_flag(fmt_flag), .data_req_in(data_req_in),
        .status_word(status_word), .status_en_n(status_en_n), .data_req_out(data_req_out)
    );

    assign msg_err_n = !fmt_flag;
    assign rt_fail_n = !fail_flag;

    assert_bc_implies_resp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bcast_hit |-> respond);
    assert_fail_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (status_upd && !st_fail) |=> rt_fail_n);
    assert_me_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_err |=> !msg_err_n);
    assert_parity_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_err_n) |-> !(^{$past(addr_strap), $past(addr_par)}));
endmodule

// File: tb/test_rt_addr_status.sv
module test_rt_addr_status;
    localparam int CLK_P = 10;
    localparam int NEN   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] addr_strap = 5'd5;
    logic addr_par = 1'b1;
    logic bcast_en = 1'b1;
    logic cmd_valid = 1'b0;
    logic [4:0] cmd_addr = '0, cmd_subaddr = '0, cmd_wcnt = '0;
    logic cmd_xmit = 1'b0, in_cmd = 1'b0, ill_cmd_n = 1'b1;
    logic srq_n = 1'b1, busy_n = 1'b1, ssflag_n = 1'b1, rtflag_n = 1'b1, adbc_n = 1'b1;
    logic status_upd = 1'b0, new_grant = 1'b0, fmt_err = 1'b0, st_fail = 1'b0, data_req_in = 1'b0;
    logic addr_err_n, respond, bcast_hit, status_en_n, msg_err_n, rt_fail_n, data_req_out;
    logic [15:0] status_word;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    rt_addr_status #(.STAT_EN_CYCLES(NEN)) i_rt_addr_status (
        .clk(clk), .rst_n(rst_n), .addr_strap(addr_strap), .addr_par(addr_par),
        .bcast_en(bcast_en), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
        .cmd_xmit(cmd_xmit), .cmd_subaddr(cmd_subaddr), .cmd_wcnt(cmd_wcnt),
        .in_cmd(in_cmd), .ill_cmd_n(ill_cmd_n), .srq_n(srq_n), .busy_n(busy_n),
        .ssflag_n(ssflag_n), .rtflag_n(rtflag_n), .adbc_n(adbc_n),
        .status_upd(status_upd), .new_grant(new_grant), .fmt_err(fmt_err),
        .st_fail(st_fail), .data_req_in(data_req_in), .addr_err_n(addr_err_n),
        .respond(respond), .bcast_hit(bcast_hit), .status_word(status_word),
        .status_en_n(status_en_n), .msg_err_n(msg_err_n), .rt_fail_n(rt_fail_n),
        .data_req_out(data_req_out)
    );

    // behavioural reference model
    bit m_aerr_n = 1, m_resp = 0, m_bc = 0, m_xmit = 0, m_dbc = 0;
    bit m_inc = 0, m_ill = 0, m_fmt = 0, m_fail = 0;
    logic [15:0] m_word = '0;
    int m_left = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_aerr_n = 1; m_resp = 0; m_bc = 0; m_xmit = 0; m_dbc = 0;
            m_inc = 0; m_ill = 0; m_fmt = 0; m_fail = 0; m_word = '0; m_left = 0;
        end else begin
            bit par_ok, bc, trig, nill, nfmt, nfail;
            par_ok = ($countones({addr_strap, addr_par}) % 2) == 1;
            bc = bcast_en && cmd_addr == 31;
            trig = in_cmd && !m_inc && !ill_cmd_n;
            nill = trig ? 1'b1 : (new_grant ? 1'b0 : m_ill);
            nfmt = fmt_err ? 1'b1 : (new_grant ? 1'b0 : m_fmt);
            nfail = st_fail ? 1'b1 : (status_upd ? 1'b0 : m_fail);
            if (m_left > 0) m_left--;
            if (status_upd) begin
                m_word = {addr_strap, m_ill | m_fmt, 1'b0, !srq_n, 3'b000, m_bc,
                          !busy_n, !ssflag_n, !adbc_n && m_dbc && m_resp && !m_ill, !rtflag_n};
                m_left = NEN;
            end
            if (cmd_valid) begin
                m_resp = bc || (par_ok && cmd_addr == addr_strap && cmd_addr != 31);
                m_bc = bc;
                m_xmit = cmd_xmit;
                m_dbc = (cmd_subaddr == 0 || cmd_subaddr == 31) && cmd_wcnt == 0 && cmd_xmit;
            end
            m_aerr_n = par_ok; m_inc = in_cmd; m_ill = nill; m_fmt = nfmt; m_fail = nfail;
        end
    end

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R1 addr_err_n", 16'(addr_err_n), 16'(m_aerr_n));
        chk("R2 respond", 16'(respond), 16'(m_resp));
        chk("R3 bcast_hit", 16'(bcast_hit), 16'(m_bc));
        chk("R3 bcast status bit", 16'(status_word[4]), 16'(m_word[4]));
        chk("R4 host bits", 16'({status_word[8], status_word[3:2], status_word[0]}),
            16'({m_word[8], m_word[3:2], m_word[0]}));
        chk("R5 dbc accept bit", 16'(status_word[1]), 16'(m_word[1]));
        chk("R6 message error bit", 16'(status_word[10]), 16'(m_word[10]));
        chk("R7 data_req_out", 16'(data_req_out), 16'(data_req_in && !(m_xmit && m_word[3])));
        chk("R8 msg_err_n", 16'(msg_err_n), 16'(!m_fmt));
        chk("R9 rt_fail_n", 16'(rt_fail_n), 16'(!m_fail));
        chk("R10 word layout", {status_word[15:11], status_word[9], status_word[7:5]},
            {7'b0, m_word[15:11], m_word[9], m_word[7:5]});
        chk("R10 status_en_n", 16'(status_en_n), 16'(m_left == 0));
    endtask

    task automatic step();
        @(posedge clk);
        #(CLK_P/4);
        compare_all();
        @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset addr_err_n", 16'(addr_err_n), 16'd1);
        chk("R10 reset status_en_n", 16'(status_en_n), 16'd1);
        chk("R10 reset word", status_word, 16'h0000);
        rst_n = 1'b1;
        // directed: even parity strap, then individual command ignored, broadcast accepted
        addr_par = 1'b0;
        step();
        cmd_valid = 1'b1; cmd_addr = 5'd5;
        step();
        cmd_addr = 5'd31;
        step();
        bcast_en = 1'b0;
        step();
        cmd_valid = 1'b0; addr_par = 1'b1;
        step();
        for (int i = 0; i < 6000; i++) begin
            cmd_valid   = ($urandom % 4) == 0;
            case ($urandom % 3)
                0: cmd_addr = addr_strap;
                1: cmd_addr = 5'd31;
                default: cmd_addr = 5'($urandom);
            endcase
            cmd_xmit    = 1'($urandom);
            cmd_subaddr = ($urandom % 2) ? (($urandom % 2) ? 5'd0 : 5'd31) : 5'($urandom);
            cmd_wcnt    = ($urandom % 2) ? 5'd0 : 5'($urandom);
            if (($urandom % 3) == 0) in_cmd = !in_cmd;
            ill_cmd_n   = ($urandom % 3) != 0;
            srq_n = 1'($urandom); busy_n = 1'($urandom); ssflag_n = 1'($urandom);
            rtflag_n = 1'($urandom); adbc_n = 1'($urandom);
            status_upd  = ($urandom % 7) == 0;
            new_grant   = ($urandom % 8) == 0;
            fmt_err     = ($urandom % 16) == 0;
            st_fail     = ($urandom % 16) == 0;
            data_req_in = 1'($urandom);
            if (($urandom % 32) == 0) begin
                addr_strap = 5'($urandom);
                addr_par = 1'($urandom);
            end
            if (($urandom % 16) == 0) bcast_en = !bcast_en;
            step();
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule